// File: doc/BRIEF.md
# Bit-Sliced Eight-Bit ALU with Signed Set-Less-Than

This block is a purely combinational arithmetic logic unit. It takes two operands and a three-bit operation code. It returns a result word and a signed overflow flag. The datapath is a ripple chain of identical one-bit slices, one for each result bit.

Each slice can invert either operand. It carries a carry in and a carry out, and it has a "less" input that it can pass straight to its result bit. Six of the seven codes are steered through two operand-inversion controls, a chain carry-in and a per-slice output pick:

- AND and OR go straight through the slices.
- NAND and NOR invert both operands and swap the gate (De Morgan).
- Add uses a carry-in of zero.
- Subtract inverts the second operand and sets the first carry to one.

Set-less-than runs the subtraction. A small flag stage beside the most significant slice turns it into a signed verdict. That verdict goes back into the least significant slice, and every other slice outputs zero.

The block has no clock and no state. An instantiating design registers the inputs or outputs where its timing needs it. Operation code 7 is not used: its result and flag are unspecified.

Top module: `alu8_sliced`

## Requirements
- R1: Code 0 returns the bitwise AND of the operands and code 1 returns the bitwise OR.
- R2: Code 2 returns the bitwise NAND of the operands and code 3 returns the bitwise NOR.
- R3: Code 4 returns the two's-complement sum, truncated to the operand width.
- R4: Code 5 returns the first operand minus the second, truncated to the operand width.
- R5: Under code 4, the overflow flag is 1 exactly when both operands have the same sign and the sum's sign differs from it.
- R6: Under code 5, the overflow flag is 1 exactly when the operands' signs differ and the difference's sign differs from the first operand's.
- R7: Code 6 returns 1 in bit 0 when the first operand is less than the second as signed numbers, otherwise 0. All higher result bits are 0.
- R8: Set-less-than stays correct when the internal subtraction overflows (for example -128 against 127 in either order).
- R9: Equal operands give 0 under set-less-than, and give a zero difference with no overflow under subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | First operand, two's complement |
| b_in | input | 8 | Second operand, two's complement |
| op_sel | input | 3 | Operation code (0 AND, 1 OR, 2 NAND, 3 NOR, 4 add, 5 subtract, 6 set-less-than) |
| result_out | output | 8 | Operation result |
| ovf_out | output | 1 | Signed overflow; meaningful for codes 4 and 5 only |

## Verification
The block holds no state, so a wrong control decode or a broken carry link shows at the ports in the same evaluation as the input change that exposes it.

- An inversion control stuck at the wrong value corrupts NAND, NOR or subtract for most operand pairs.
- A carry-chain fault shows only when a carry has to travel through the faulty link.
- A wrong set derivation, such as using the raw sign without the overflow correction, shows only when the subtraction overflows.

For the carry-chain and set-derivation faults, random operand pairs are combined with the extreme cases 127+1, -128-1 and -128 against 127.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Shared operation codes, slice output picks and the decoded control bundle
// for the bit-sliced ALU. Assumes a three-bit operation code.
package alu8_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_NAND = 3'd2,
        OP_NOR  = 3'd3,
        OP_ADD  = 3'd4,
        OP_SUB  = 3'd5,
        OP_SLT  = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_LESS = 2'd3
    } slice_pick_e;

    typedef struct packed {
        logic        inv_a;
        logic        inv_b;
        logic        carry0;
        slice_pick_e pick;
    } slice_ctrl_t;

endpackage

// File: rtl/alu8_ctrl_decode.sv
// Module alu8_ctrl_decode
// Turns the operation code into the controls shared by every slice:
// operand inversions, the carry into bit 0 and the slice output pick.
// Assumes code 7 never arrives; it decodes to AND as a harmless default.
module alu8_ctrl_decode
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output slice_ctrl_t     ctrl
);

    // Purpose: map each operation onto inversion, carry and pick settings.
    always_comb begin
        ctrl = '{inv_a: 1'b0, inv_b: 1'b0, carry0: 1'b0, pick: PICK_AND};
        unique case (alu_op_e'(op_code))
            OP_AND:  ctrl.pick = PICK_AND;
            OP_OR:   ctrl.pick = PICK_OR;
            OP_NAND: begin ctrl.inv_a = 1'b1; ctrl.inv_b = 1'b1; ctrl.pick = PICK_OR;  end
            OP_NOR:  begin ctrl.inv_a = 1'b1; ctrl.inv_b = 1'b1; ctrl.pick = PICK_AND; end
            OP_ADD:  ctrl.pick = PICK_SUM;
            OP_SUB:  begin ctrl.inv_b = 1'b1; ctrl.carry0 = 1'b1; ctrl.pick = PICK_SUM;  end
            OP_SLT:  begin ctrl.inv_b = 1'b1; ctrl.carry0 = 1'b1; ctrl.pick = PICK_LESS; end
            default: ctrl.pick = PICK_AND;
        endcase
    end

    // Purpose: subtract and compare must always push a carry of one into bit 0 (R4, R7).
    always_comb begin
        if (ctrl.inv_b && !ctrl.inv_a) begin
            assert_sub_carry_R4: assert (ctrl.carry0)
                else $error("inverted b without carry-in of one");
        end
    end

endmodule

// File: rtl/alu8_bit_slice.sv
// Module alu8_bit_slice
// One bit of the ALU. Optionally inverts each operand, then forms AND, OR
// and a full-adder sum with carry out. The pick selects which of these, or
// the external "less" bit, drives the result bit. It holds no state.
module alu8_bit_slice
    import alu8_pkg::*;
(
    input  logic        op_a,
    input  logic        op_b,
    input  slice_ctrl_t ctrl,
    input  logic        carry_in,
    input  logic        less_in,
    output logic        res_bit,
    output logic        sum_bit,
    output logic        carry_out
);

    logic a_eff;
    logic b_eff;

    // Purpose: apply operand inversions and compute the full-adder outputs.
    always_comb begin
        a_eff     = op_a ^ ctrl.inv_a;
        b_eff     = op_b ^ ctrl.inv_b;
        sum_bit   = a_eff ^ b_eff ^ carry_in;
        carry_out = (a_eff & b_eff) | (carry_in & (a_eff ^ b_eff));
    end

    // Purpose: choose the slice's result bit.
    always_comb begin
        unique case (ctrl.pick)
            PICK_AND:  res_bit = a_eff & b_eff;
            PICK_OR:   res_bit = a_eff | b_eff;
            PICK_SUM:  res_bit = sum_bit;
            PICK_LESS: res_bit = less_in;
            default:   res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu8_msb_flags.sv
// Module alu8_msb_flags
// Sits beside the most significant slice. Derives signed overflow from the
// carries into and out of that slice. Derives the signed less-than verdict
// as the difference's sign corrected by that overflow.
// Assumes the slices are subtracting whenever the verdict is used.
module alu8_msb_flags (
    input  logic msb_carry_in,
    input  logic msb_carry_out,
    input  logic msb_sum,
    output logic ovf,
    output logic set_less
);

    // Purpose: overflow from the top carries and an overflow-corrected sign.
    always_comb begin
        ovf      = msb_carry_in ^ msb_carry_out;
        set_less = msb_sum ^ ovf;
    end

endmodule

// File: rtl/alu8_sliced.sv
// Module alu8_sliced
// Top of the bit-sliced ALU. One decoder drives WIDTH identical slices that
// are chained by their carries. The flag stage at the top slice gives the
// overflow and the less-than verdict, which is fed into bit 0's less input.
// Purely combinational; assumes WIDTH >= 2 and op_sel never equals 7.
module alu8_sliced
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [OP_W-1:0]  op_sel,
    output logic [WIDTH-1:0] result_out,
    output logic             ovf_out
);

    localparam int MSB = WIDTH - 1;

    slice_ctrl_t ctrl;
    logic        set_less;

    alu8_ctrl_decode u_decode (
        .op_code (op_sel),
        .ctrl    (ctrl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic cin_bit;
        logic less_bit;
        logic sum_bit;
        logic cout_bit;

        if (i == 0) begin : g_first
            assign cin_bit  = ctrl.carry0;
            assign less_bit = set_less;
        end else begin : g_rest
            assign cin_bit  = g_slice[i-1].cout_bit;
            assign less_bit = 1'b0;
        end

        alu8_bit_slice u_slice (
            .op_a      (a_in[i]),
            .op_b      (b_in[i]),
            .ctrl      (ctrl),
            .carry_in  (cin_bit),
            .less_in   (less_bit),
            .res_bit   (result_out[i]),
            .sum_bit   (sum_bit),
            .carry_out (cout_bit)
        );

        // Purpose: in add mode each slice's adder output reaches its result bit (R3).
        always_comb begin
            if (op_sel == OP_ADD) begin
                assert_sum_route_R3: assert (sum_bit == result_out[i])
                    else $error("slice sum not routed to result");
            end
        end
    end

    alu8_msb_flags u_flags (
        .msb_carry_in  (g_slice[MSB].cin_bit),
        .msb_carry_out (g_slice[MSB].cout_bit),
        .msb_sum       (g_slice[MSB].sum_bit),
        .ovf           (ovf_out),
        .set_less      (set_less)
    );

    // Purpose: port-level checks of arithmetic, flags and comparison.
    always_comb begin
        if (op_sel == OP_ADD) begin
            assert_add_value_R3: assert (result_out == WIDTH'(a_in + b_in))
                else $error("sum mismatch");
            assert_add_overflow_R5: assert (ovf_out ==
                ((a_in[MSB] == b_in[MSB]) && (result_out[MSB] != a_in[MSB])))
                else $error("add overflow mismatch");
        end
        if (op_sel == OP_SUB) begin
            assert_sub_value_R4: assert (result_out == WIDTH'(a_in - b_in))
                else $error("difference mismatch");
            assert_sub_overflow_R6: assert (ovf_out ==
                ((a_in[MSB] != b_in[MSB]) && (result_out[MSB] != a_in[MSB])))
                else $error("sub overflow mismatch");
        end
        if (op_sel == OP_SLT) begin
            assert_slt_value_R7: assert (result_out ==
                WIDTH'($signed(a_in) < $signed(b_in)))
                else $error("set-less-than mismatch");
        end
        if (op_sel == OP_NAND) begin
            assert_nand_value_R2: assert (result_out == ~(a_in & b_in))
                else $error("nand mismatch");
        end
    end

endmodule

// File: tb/alu8_sliced_bench.sv
// Bench alu8_sliced_bench
// Drives operand pairs on each rising edge and compares with a behavioural
// integer model at the following falling edge.
module alu8_sliced_bench;

    localparam int PERIOD   = 10;
    localparam int W        = 8;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic [2:0]   op_sel;
    logic [W-1:0] result_out;
    logic         ovf_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    alu8_sliced #(.WIDTH(W)) u_alu8_sliced (
        .a_in       (a_in),
        .b_in       (b_in),
        .op_sel     (op_sel),
        .result_out (result_out),
        .ovf_out    (ovf_out)
    );

    // Behavioural model: result for a code.
    function automatic logic [W-1:0] model_res(input logic [W-1:0] a, input logic [W-1:0] b, input int op);
        int sa = $signed(a);
        int sb = $signed(b);
        case (op)
            0: return a & b;
            1: return a | b;
            2: return ~(a & b);
            3: return ~(a | b);
            4: return W'(sa + sb);
            5: return W'(sa - sb);
            6: return (sa < sb) ? W'(1) : W'(0);
            default: return '0;
        endcase
    endfunction

    // Behavioural model: signed overflow for add (4) and subtract (5).
    function automatic logic model_ovf(input logic [W-1:0] a, input logic [W-1:0] b, input int op);
        int sa = $signed(a);
        int sb = $signed(b);
        int r  = (op == 4) ? sa + sb : sa - sb;
        return (r > 127) || (r < -128);
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1: return "R1";
            2, 3: return "R2";
            4:    return "R3";
            5:    return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a rising edge, compare at the next falling edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input int op, input string tag);
        @(posedge clk);
        a_in   = a;
        b_in   = b;
        op_sel = 3'(op);
        @(negedge clk);
        check(tag, result_out, model_res(a, b, op));
        if (op == 4) check("R5", W'(ovf_out), W'(model_ovf(a, b, op)));
        if (op == 5) check("R6", W'(ovf_out), W'(model_ovf(a, b, op)));
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            report();
        end
    end

    initial begin
        a_in = '0; b_in = '0; op_sel = '0;
        @(negedge clk);
        check("R1 idle", result_out, 8'h00);

        // Patterned operands through all seven codes.
        for (int op = 0; op < 7; op++) begin
            apply(8'hF0, 8'h3C, op, tag_of(op));
            apply(8'h55, 8'hAA, op, tag_of(op));
            apply(8'hFF, 8'h01, op, tag_of(op));
        end

        // Extremes for R3/R5 and R4/R6.
        apply(8'h7F, 8'h01, 4, "R3 127+1");
        apply(8'h80, 8'hFF, 4, "R3 -128+-1");
        apply(8'h80, 8'h01, 5, "R4 -128-1");
        apply(8'h7F, 8'hFF, 5, "R4 127-(-1)");

        // R8: comparisons whose subtraction overflows.
        apply(8'h80, 8'h7F, 6, "R8 -128<127");
        apply(8'h7F, 8'h80, 6, "R8 127<-128");
        apply(8'hFF, 8'h00, 6, "R7 -1<0");

        // R9: equal operands.
        apply(8'h05, 8'h05, 6, "R9 slt equal");
        apply(8'h80, 8'h80, 6, "R9 slt equal min");
        apply(8'h05, 8'h05, 5, "R9 sub equal");
        apply(8'h7F, 8'h7F, 5, "R9 sub equal max");

        // Random operand pairs through every code.
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] ra = W'($urandom);
            logic [W-1:0] rb = W'($urandom);
            for (int op = 0; op < 7; op++) apply(ra, rb, op, tag_of(op));
        end

        done = 1'b1;
        report();
    end

endmodule